// File: doc/BRIEF.md
# Two-Road Demand-Driven Signal Controller

This block drives the signals at a crossing of a north-south road and an east-west road. Each road shows only green or red. At every moment exactly one road is green. One car detector per road tells the block whether a vehicle is waiting. The block does not act on the detectors in every clock cycle. An internal interval timer gives a single-cycle decision strobe at a fixed period, 30 seconds by default. The green moves to the other road only at such a strobe, and only if the red road has a waiting car.

The controller has two named states. `PH_NS_GO` has north-south green and east-west red. `PH_EW_GO` has east-west green and north-south red. There are two named transitions. `T_GIVE_EW` goes from `PH_NS_GO` to `PH_EW_GO`. It is taken at a strobe when the east-west detector is set, whatever the north-south detector shows. `T_GIVE_NS` goes from `PH_EW_GO` to `PH_NS_GO`. It is taken at a strobe when the north-south detector is set, whatever the east-west detector shows. Every other case stays in the current state.

Each detector passes through a two-flop synchroniser before the transition logic sees it. The interval timer counts clock cycles per second and then seconds per interval. Both counts are parameters, so simulation can use a short period.

Top module: `xing_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the block is in `PH_NS_GO`: north-south green and east-west red.
- R2: In every cycle, exactly one of the two green outputs is 1. Each road's red output is the inverse of its green output.
- R3: The state changes only on the clock edge that ends a strobe cycle. With a period P = CLK_PER_SEC * INTERVAL_SEC, the strobe cycles are those that follow edge P-1, 2P-1, and so on, counted from the release of reset. The state never changes at any other edge.
- R4: In `PH_NS_GO`, a strobe with the synchronised east-west detector set and the north-south detector clear moves the block to `PH_EW_GO`.
- R5: In `PH_NS_GO`, a strobe with both detectors set also moves the block to `PH_EW_GO`.
- R6: In `PH_NS_GO`, a strobe with the east-west detector clear keeps north-south green, even when the north-south detector is set.
- R7: In `PH_EW_GO`, a strobe with the north-south detector set moves the block to `PH_NS_GO`, whatever the east-west detector shows. A strobe with the north-south detector clear keeps east-west green.
- R8: A detector is used only after two clock edges of synchronisation. A detector that first rises after the edge just before a decision edge has no effect at that decision. If it is still held, it takes effect at the next decision.
- R9: Reset clears the interval timer. The first decision after reset is released falls at edge P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| car_ns_i | input | 1 | North-south car detector, asynchronous to clk |
| car_ew_i | input | 1 | East-west car detector, asynchronous to clk |
| ns_green_o | output | 1 | North-south green |
| ns_red_o | output | 1 | North-south red |
| ew_green_o | output | 1 | East-west green |
| ew_red_o | output | 1 | East-west red |

## Verification
Two functions can fall in the same cycle: the decision strobe, and the first synchroniser stage capturing a new detector value. The bench provokes this by raising a detector just after the edge that opens the strobe cycle. The decision edge then captures the new value into the first stage while the transition logic still reads the old synchronised value. The bench judges the result in two steps: the green must not move at that decision, and it must move at the following decision if the detector is still held.

// File: rtl/xing_pkg.sv
package xing_pkg;

    // One bit of state: which road holds green.
    typedef enum logic [0:0] {
        PH_NS_GO = 1'b0,
        PH_EW_GO = 1'b1
    } phase_t;

    // Bit positions in the detector vector.
    localparam int ROAD_NS = 0;
    localparam int ROAD_EW = 1;
    localparam int ROADS   = 2;

endpackage

// File: rtl/xing_sync.sv
module xing_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

    // R8
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stage_q[0] == $past(d_i)));

endmodule

// File: rtl/xing_tick.sv
module xing_tick #(
    parameter int CLK_PER_SEC  = 125_000_000,
    parameter int INTERVAL_SEC = 30
) (
    input  logic clk,
    input  logic rst,
    output logic strobe_o
);

    localparam int PW = (CLK_PER_SEC  > 1) ? $clog2(CLK_PER_SEC)  : 1;
    localparam int IW = (INTERVAL_SEC > 1) ? $clog2(INTERVAL_SEC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_SEC - 1);
    localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL_SEC - 1);

    logic [PW-1:0] pre_q;
    logic [IW-1:0] ivl_q;
    logic          sec_end;

    assign sec_end = (pre_q == PRE_LAST);

    // Counts clock cycles within one second.
    always_ff @(posedge clk) begin
        if (rst)          pre_q <= '0;
        else if (sec_end) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    // Counts seconds within one interval.
    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_q <= '0;
        end else if (sec_end) begin
            if (ivl_q == IVL_LAST) ivl_q <= '0;
            else                   ivl_q <= ivl_q + 1'b1;
        end
    end

    assign strobe_o = sec_end && (ivl_q == IVL_LAST);

    // R9
    tick_clear_chk: assert property (@(posedge clk)
        rst |=> (pre_q == '0 && ivl_q == '0));

    // R3
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> (pre_q == '0 && ivl_q == '0));

endmodule

// File: rtl/xing_fsm.sv
module xing_fsm
    import xing_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic car_ns_i,
    input  logic car_ew_i,
    output logic ns_green_o,
    output logic ew_green_o
);

    phase_t state_q;
    phase_t state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_NS_GO;
        else     state_q <= state_d;
    end

    // Transitions T_GIVE_EW and T_GIVE_NS.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_NS_GO: if (strobe_i && car_ew_i) state_d = PH_EW_GO;
            PH_EW_GO: if (strobe_i && car_ns_i) state_d = PH_NS_GO;
            default:  state_d = PH_NS_GO;
        endcase
    end

    // Output decode.
    always_comb begin
        ns_green_o = 1'b0;
        ew_green_o = 1'b0;
        unique case (state_q)
            PH_NS_GO: ns_green_o = 1'b1;
            PH_EW_GO: ew_green_o = 1'b1;
            default:  ns_green_o = 1'b1;
        endcase
    end

    // R1
    reset_phase_chk: assert property (@(posedge clk)
        rst |=> (state_q == PH_NS_GO));

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(state_q));

    // R4
    give_ew_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_NS_GO && strobe_i && car_ew_i) |=> (state_q == PH_EW_GO));

    // R6
    keep_ns_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_NS_GO && !car_ew_i) |=> (state_q == PH_NS_GO));

    // R7
    give_ns_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_EW_GO && strobe_i && car_ns_i) |=> (state_q == PH_NS_GO));

endmodule

// File: rtl/xing_ctrl.sv
module xing_ctrl
    import xing_pkg::*;
#(
    parameter int CLK_PER_SEC  = 125_000_000,
    parameter int INTERVAL_SEC = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic car_ns_i,
    input  logic car_ew_i,
    output logic ns_green_o,
    output logic ns_red_o,
    output logic ew_green_o,
    output logic ew_red_o
);

    logic [ROADS-1:0] car_raw;
    logic [ROADS-1:0] car_sync;
    logic             strobe;
    logic             ns_go;
    logic             ew_go;

    assign car_raw[ROAD_NS] = car_ns_i;
    assign car_raw[ROAD_EW] = car_ew_i;

    xing_sync #(
        .WIDTH  (ROADS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (car_raw),
        .q_o (car_sync)
    );

    xing_tick #(
        .CLK_PER_SEC  (CLK_PER_SEC),
        .INTERVAL_SEC (INTERVAL_SEC)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .strobe_o (strobe)
    );

    xing_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strobe_i   (strobe),
        .car_ns_i   (car_sync[ROAD_NS]),
        .car_ew_i   (car_sync[ROAD_EW]),
        .ns_green_o (ns_go),
        .ew_green_o (ew_go)
    );

    assign ns_green_o = ns_go;
    assign ew_green_o = ew_go;
    assign ns_red_o   = ~ns_go;
    assign ew_red_o   = ~ew_go;

    // R2
    one_green_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_green_o, ew_green_o}) == 1);

    // R2
    red_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (ns_red_o != ns_green_o) && (ew_red_o != ew_green_o));

endmodule

// File: tb/xing_ctrl_tb.sv
`timescale 1ns/1ps
module xing_ctrl_tb;

    localparam int CPS = 4;
    localparam int IVS = 3;
    localparam int P   = CPS * IVS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_ns = 1'b0;
    logic car_ew = 1'b0;
    logic ns_g, ns_r, ew_g, ew_r;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xing_ctrl #(
        .CLK_PER_SEC  (CPS),
        .INTERVAL_SEC (IVS)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .car_ns_i   (car_ns),
        .car_ew_i   (car_ew),
        .ns_green_o (ns_g),
        .ns_red_o   (ns_r),
        .ew_green_o (ew_g),
        .ew_red_o   (ew_r)
    );

    // Edges since reset release, in step with the interval rule of R3.
    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at edge %0d", req, what, act, exp, edge_n);
        end
    endtask

    // Phase 1 means east-west green.
    task automatic check_phase(input string req, input logic exp_ew);
        check(req, ew_g, exp_ew, "ew_green");
        check(req, ns_g, ~exp_ew, "ns_green");
    endtask

    task automatic wait_to(input int r);
        do begin
            @(posedge clk); #1;
        end while ((edge_n % P) != r);
    endtask

    // Per-cycle monitor: R2 one green, R3 no change off the decision edges.
    logic prev_ew;
    bit   have_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            have_prev = 1'b0;
        end else begin
            check("R2", ns_g ^ ew_g, 1'b1, "exactly one green");
            check("R2", (ns_r == ~ns_g) && (ew_r == ~ew_g), 1'b1, "red inverse");
            if (have_prev && (ew_g != prev_ew) && ((edge_n % P) != 0))
                check("R3", ew_g, prev_ew, "change off decision edge");
            prev_ew   = ew_g;
            have_prev = 1'b1;
        end
    end

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_phase("R1", 1'b0);
        check("R1", ns_r, 1'b0, "ns_red");
        check("R1", ew_r, 1'b1, "ew_red");
        rst = 1'b0;
    endtask

    task automatic t_ns_stay;
        car_ns = 1'b1; car_ew = 1'b0;
        wait_to(P-1); check_phase("R6", 1'b0);
        wait_to(0);   check_phase("R6", 1'b0);
    endtask

    task automatic t_ns_to_ew;
        car_ns = 1'b0; car_ew = 1'b1;
        wait_to(P-1); check_phase("R3", 1'b0);
        wait_to(0);   check_phase("R4", 1'b1);
    endtask

    task automatic t_ew_stay;
        car_ns = 1'b0; car_ew = 1'b1;
        wait_to(0); check_phase("R7", 1'b1);
    endtask

    task automatic t_ew_to_ns_both;
        car_ns = 1'b1; car_ew = 1'b1;
        wait_to(P-1); check_phase("R3", 1'b1);
        wait_to(0);   check_phase("R7", 1'b0);
    endtask

    task automatic t_ns_both;
        car_ns = 1'b1; car_ew = 1'b1;
        wait_to(0); check_phase("R5", 1'b1);
    endtask

    task automatic t_late_request;
        car_ns = 1'b0; car_ew = 1'b0;
        wait_to(P-1);
        car_ns = 1'b1;
        wait_to(0); check_phase("R8", 1'b1);
        wait_to(0); check_phase("R8", 1'b0);
    endtask

    task automatic t_reset_mid;
        car_ns = 1'b0; car_ew = 1'b1;
        wait_to(5);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_phase("R1", 1'b0);
        rst = 1'b0;
        repeat (P-1) @(posedge clk);
        #1;
        check_phase("R9", 1'b0);
        @(posedge clk); #1;
        check_phase("R9", 1'b1);
    endtask

    initial begin
        t_reset();
        t_ns_stay();
        t_ns_to_ew();
        t_ew_stay();
        t_ew_to_ns_both();
        t_ns_both();
        t_late_request();
        t_reset_mid();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule